// File: doc/BRIEF.md
# Float-to-Unsigned Truncating Converter

This unit turns a 32-bit single-precision floating-point operand into a 32-bit unsigned integer. Any fraction is dropped, so the result always moves toward zero. The operand is presented together with a one-cycle valid strobe. One clock later the unit raises a done strobe and presents the integer, two exception flags (invalid and inexact), and a summary flag that a status register elsewhere in the chip can sample.

Special operands are settled before any arithmetic takes place:

- NaN and negative non-zero values give zero and raise invalid.
- Values of 2^32 or more, and positive infinity, saturate to all ones and raise invalid.
- Positive values below one, including denormals, give zero and raise inexact.

Only one flag can be raised per conversion, and invalid always takes priority over inexact. The result, flags and summary keep their values until the next conversion.

Top module: `fcvt_trunc_u32`

## Requirements
- R1: Every cycle with `in_valid` high is followed, in the next cycle only, by `out_done` high. `out_done` is low in every other cycle.
- R2: For a positive operand from 1.0 up to below 2^32, `out_result` is the integer part of the operand. Examples: 0x3F800000 gives 1, and 0x4F7FFFFF gives 0xFFFFFF00.
- R3: In that same range, `out_inexact` is 1 exactly when the operand has a non-zero fraction (0x3FC00000, which is 1.5, gives 1 with inexact). Exact integers leave it at 0.
- R4: Any NaN gives result 0 with `out_invalid` = 1. A NaN has exponent field bits[30:23] = 0xFF and a non-zero mantissa field bits[22:0], whatever its sign or quiet bit.
- R5: Any operand with sign bit[31] = 1 that is not zero gives result 0 with `out_invalid` = 1. This covers -0.5, negative denormals and negative infinity.
- R6: A positive operand of 2^32 (0x4F800000) or larger, or positive infinity (0x7F800000), gives 0xFFFFFFFF with `out_invalid` = 1.
- R7: Positive zero (0x00000000) and negative zero (0x80000000) both give 0, with both flags clear.
- R8: A positive non-zero operand below 1.0, denormals included, gives 0 with `out_inexact` = 1.
- R9: `out_invalid` and `out_inexact` are never both 1. When invalid is raised, inexact is 0.
- R10: `out_flag_any` equals the OR of `out_invalid` and `out_inexact`. It is therefore 0 when the conversion raised no exception.
- R11: While `rst` is high, and after reset until the first conversion, all outputs are 0.
- R12: In cycles without `in_valid`, the result and all flags keep the values of the last conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Start a conversion of `in_operand` this cycle |
| in_operand | input | 32 | Single-precision operand |
| out_done | output | 1 | Result of the previous cycle's request is present |
| out_result | output | 32 | Truncated unsigned integer |
| out_invalid | output | 1 | Operand is NaN, negative or out of range |
| out_inexact | output | 1 | Fraction was discarded from a valid result |
| out_flag_any | output | 1 | Summary: any exception flag raised |

## Verification
The bound checker looks at every cycle. It checks the one-cycle done timing and the holding of outputs while the unit is idle. It checks that the two flags never appear together and that the summary matches them. It also checks the fixed outcomes for each special operand class: NaN, negative, overflow, zero and tiny.

Only the bench's scenarios can show that the integer value is correct. The bench compares against a real-valued truncation model across exponents 126 to 158, at the mantissa extremes and with pseudo-random operands. It shows that inexact tracks the discarded fraction bits and that the unit comes out of reset in a clean state.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
    localparam int EXP_W   = 8;
    localparam int MAN_W   = 23;
    localparam int FP_W    = 1 + EXP_W + MAN_W;
    localparam int INT_W   = 32;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int OVF_EXP = BIAS + INT_W;          // first exponent whose value reaches 2^INT_W
    localparam int SH_W    = $clog2(INT_W);
    localparam int FX_W    = INT_W + MAN_W;         // fixed-point width: integer part over fraction

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_NAN,
        CLS_NEG,
        CLS_OVF,
        CLS_TINY,
        CLS_NORM
    } op_class_e;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] expo;
        logic [MAN_W-1:0] man;
    } fp_fields_t;

    typedef struct packed {
        op_class_e        cls;
        logic [MAN_W:0]   sig;
        logic [SH_W-1:0]  shamt;
    } decoded_t;

    typedef struct packed {
        logic [INT_W-1:0] value;
        logic             invalid;
        logic             inexact;
    } conv_res_t;

    function automatic logic op_is_nan(input logic [FP_W-1:0] x);
        fp_fields_t f;
        f = fp_fields_t'(x);
        return (f.expo == '1) && (f.man != '0);
    endfunction

    function automatic logic op_is_zero(input logic [FP_W-1:0] x);
        fp_fields_t f;
        f = fp_fields_t'(x);
        return (f.expo == '0) && (f.man == '0);
    endfunction

    function automatic logic op_is_neg(input logic [FP_W-1:0] x);
        fp_fields_t f;
        f = fp_fields_t'(x);
        return f.sign && !op_is_zero(x) && !op_is_nan(x);
    endfunction

    function automatic logic op_is_ovf(input logic [FP_W-1:0] x);
        fp_fields_t f;
        f = fp_fields_t'(x);
        return !f.sign && !op_is_nan(x) && (int'(f.expo) >= OVF_EXP);
    endfunction

    function automatic logic op_is_tiny(input logic [FP_W-1:0] x);
        fp_fields_t f;
        f = fp_fields_t'(x);
        return !f.sign && !op_is_zero(x) && (int'(f.expo) < BIAS);
    endfunction
endpackage

// File: rtl/fcvt_classify.sv
module fcvt_classify
    import fcvt_pkg::*;
(
    input  logic [FP_W-1:0] operand,
    output decoded_t        dec
);
    fp_fields_t fld;

    always_comb begin
        fld       = fp_fields_t'(operand);
        dec.sig   = {(fld.expo != '0), fld.man};
        dec.shamt = SH_W'(fld.expo - EXP_W'(BIAS));
        if (op_is_nan(operand))
            dec.cls = CLS_NAN;
        else if (op_is_zero(operand))
            dec.cls = CLS_ZERO;
        else if (fld.sign)
            dec.cls = CLS_NEG;
        else if (int'(fld.expo) >= OVF_EXP)
            dec.cls = CLS_OVF;
        else if (int'(fld.expo) < BIAS)
            dec.cls = CLS_TINY;
        else
            dec.cls = CLS_NORM;
    end
endmodule

// File: rtl/fcvt_align.sv
module fcvt_align
    import fcvt_pkg::*;
(
    input  logic [MAN_W:0]   sig,
    input  logic [SH_W-1:0]  shamt,
    output logic [INT_W-1:0] int_part,
    output logic             sticky
);
    logic [SH_W:0][FX_W-1:0] stage;

    assign stage[0] = {{(FX_W - MAN_W - 1){1'b0}}, sig};

    for (genvar i = 0; i < SH_W; i++) begin : g_shift
        assign stage[i+1] = shamt[i] ? (stage[i] << (1 << i)) : stage[i];
    end

    assign int_part = stage[SH_W][FX_W-1:MAN_W];
    assign sticky   = |stage[SH_W][MAN_W-1:0];
endmodule

// File: rtl/fcvt_select.sv
module fcvt_select
    import fcvt_pkg::*;
(
    input  op_class_e        cls,
    input  logic [INT_W-1:0] int_part,
    input  logic             sticky,
    output conv_res_t        res
);
    always_comb begin
        res = '0;
        case (cls)
            CLS_NAN, CLS_NEG: begin
                res.value   = '0;
                res.invalid = 1'b1;
            end
            CLS_OVF: begin
                res.value   = '1;
                res.invalid = 1'b1;
            end
            CLS_TINY: begin
                res.value   = '0;
                res.inexact = 1'b1;
            end
            CLS_NORM: begin
                res.value   = int_part;
                res.inexact = sticky;
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/fcvt_trunc_u32.sv
module fcvt_trunc_u32
    import fcvt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [FP_W-1:0]  in_operand,
    output logic             out_done,
    output logic [INT_W-1:0] out_result,
    output logic             out_invalid,
    output logic             out_inexact,
    output logic             out_flag_any
);
    decoded_t         dec;
    logic [INT_W-1:0] int_part;
    logic             sticky;
    conv_res_t        comb_res;
    conv_res_t        res_q;
    logic             any_q;
    logic             done_q;

    fcvt_classify u_classify (
        .operand (in_operand),
        .dec     (dec)
    );

    fcvt_align u_align (
        .sig      (dec.sig),
        .shamt    (dec.shamt),
        .int_part (int_part),
        .sticky   (sticky)
    );

    fcvt_select u_select (
        .cls      (dec.cls),
        .int_part (int_part),
        .sticky   (sticky),
        .res      (comb_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            any_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= in_valid;
            if (in_valid) begin
                res_q <= comb_res;
                any_q <= comb_res.invalid | comb_res.inexact;
            end
        end
    end

    assign out_done     = done_q;
    assign out_result   = res_q.value;
    assign out_invalid  = res_q.invalid;
    assign out_inexact  = res_q.inexact;
    assign out_flag_any = any_q;
endmodule

// File: rtl/fcvt_trunc_u32_chk.sv
module fcvt_trunc_u32_chk
    import fcvt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [FP_W-1:0]  in_operand,
    input logic             out_done,
    input logic [INT_W-1:0] out_result,
    input logic             out_invalid,
    input logic             out_inexact,
    input logic             out_flag_any
);
    AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_done);                                              // R1
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_done);                                            // R1
    AST_NAN_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        in_valid && op_is_nan(in_operand) |=> out_invalid && out_result == '0); // R4
    AST_NEG_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        in_valid && op_is_neg(in_operand) |=> out_invalid && out_result == '0); // R5
    AST_OVF_SATURATE: assert property (@(posedge clk) disable iff (rst)
        in_valid && op_is_ovf(in_operand) |=> out_invalid && out_result == '1); // R6
    AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (rst)
        in_valid && op_is_zero(in_operand) |=> !out_invalid && !out_inexact && out_result == '0); // R7
    AST_TINY_INEXACT: assert property (@(posedge clk) disable iff (rst)
        in_valid && op_is_tiny(in_operand) |=> out_inexact && !out_invalid && out_result == '0); // R8
    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
        out_done |-> !(out_invalid && out_inexact));                         // R9
    AST_SUMMARY_MATCH: assert property (@(posedge clk) disable iff (rst)
        out_done |-> (out_flag_any == (out_invalid || out_inexact)));        // R10
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result) && $stable(out_invalid) && $stable(out_inexact) && $stable(out_flag_any)); // R12
endmodule

bind fcvt_trunc_u32 fcvt_trunc_u32_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_operand   (in_operand),
    .out_done     (out_done),
    .out_result   (out_result),
    .out_invalid  (out_invalid),
    .out_inexact  (out_inexact),
    .out_flag_any (out_flag_any)
);

// File: tb/fcvt_trunc_u32_tb_top.sv
module fcvt_trunc_u32_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] op;
        logic [31:0] res;
        logic        inv;
        logic        inx;
        string       tag;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_operand = '0;
    logic        out_done;
    logic [31:0] out_result;
    logic        out_invalid;
    logic        out_inexact;
    logic        out_flag_any;

    exp_item_t   sb_q[$];
    exp_item_t   last_item;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;

    fcvt_trunc_u32 dut_i (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_operand   (in_operand),
        .out_done     (out_done),
        .out_result   (out_result),
        .out_invalid  (out_invalid),
        .out_inexact  (out_inexact),
        .out_flag_any (out_flag_any)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input logic [31:0] op);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s op=%h act=%h exp=%h", tag, op, act, exp);
        end
    endtask

    function automatic exp_item_t model(input logic [31:0] op);
        exp_item_t it;
        int  e;
        int  f;
        real mag;
        real fl;
        e = int'(op[30:23]);
        f = int'(op[22:0]);
        it.op = op; it.res = '0; it.inv = 1'b0; it.inx = 1'b0; it.tag = "R2";
        if (e == 255 && f != 0) begin
            it.inv = 1'b1; it.tag = "R4";
        end else if (e == 0 && f == 0) begin
            it.tag = "R7";
        end else if (op[31]) begin
            it.inv = 1'b1; it.tag = "R5";
        end else if (e == 255) begin
            it.inv = 1'b1; it.res = '1; it.tag = "R6";
        end else begin
            if (e == 0)
                mag = real'(f) * (2.0 ** (-149));
            else
                mag = (1.0 + real'(f) / 8388608.0) * (2.0 ** (e - 127));
            if (mag >= 4294967296.0) begin
                it.inv = 1'b1; it.res = '1; it.tag = "R6";
            end else begin
                fl     = $floor(mag);
                it.res = 32'(longint'(fl));
                it.inx = (fl != mag);
                if (mag < 1.0)   it.tag = "R8";
                else if (it.inx) it.tag = "R3";
                else             it.tag = "R2";
            end
        end
        return it;
    endfunction

    task automatic send(input logic [31:0] op);
        exp_item_t it;
        @(negedge clk);
        it = model(op);
        sb_q.push_back(it);
        last_item  = it;
        in_valid   = 1'b1;
        in_operand = op;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: pop and compare
    initial begin
        exp_item_t it;
        forever begin
            @(negedge clk);
            if (!rst && out_done) begin
                if (sb_q.size() == 0) begin
                    chk("R1", 32'(out_done), 32'd0, in_operand);
                end else begin
                    it = sb_q.pop_front();
                    chk(it.tag, out_result, it.res, it.op);
                    chk(it.inv ? it.tag : "R9", 32'(out_invalid), 32'(it.inv), it.op);
                    chk(it.inv ? "R9" : it.tag, 32'(out_inexact), 32'(it.inx), it.op);
                    chk("R10", 32'(out_flag_any), 32'(it.inv | it.inx), it.op);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        logic [31:0] specials [21];
        specials = '{32'h00000000, 32'h80000000, 32'h7FC00000, 32'h7F800001, 32'hFFC00000,
                     32'hBF000000, 32'hBF800000, 32'hFF800000, 32'h80000001, 32'h7F800000,
                     32'h4F800000, 32'h4F800001, 32'h7F7FFFFF, 32'h4F7FFFFF, 32'h00000001,
                     32'h007FFFFF, 32'h3F7FFFFF, 32'h3FC00000, 32'h3F800000, 32'h4B000001,
                     32'h4EFFFFFF};
        repeat (3) @(negedge clk);
        // R11: outputs clear during reset
        chk("R11", {out_result[31:1], out_done | out_invalid | out_inexact | out_flag_any | out_result[0]}, 32'd0, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11", {out_result[31:1], out_done | out_invalid | out_inexact | out_flag_any | out_result[0]}, 32'd0, 32'd0);

        foreach (specials[k]) send(specials[k]);
        idle(2);

        for (int e = 126; e <= 158; e++) begin
            send({1'b0, 8'(e), 23'h000000});
            send({1'b0, 8'(e), 23'h000001});
            send({1'b0, 8'(e), 23'h400000});
            send({1'b0, 8'(e), 23'h7FFFFF});
        end
        idle(1);

        lfsr = 32'hACE1_2468;
        for (int n = 0; n < 300; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (n % 7 == 3) idle(1);
            if (n % 2 == 0)
                send({1'b0, 8'(8'd120 + 8'(lfsr[7:0] % 45)), lfsr[30:8]});
            else
                send(lfsr ^ {lfsr[15:0], lfsr[31:16]});
        end

        // R12: outputs hold while idle
        idle(4);
        chk("R12", out_result, last_item.res, last_item.op);
        chk("R12", 32'(out_invalid), 32'(last_item.inv), last_item.op);
        chk("R12", 32'(out_inexact), 32'(last_item.inx), last_item.op);
        chk("R1", 32'(out_done), 32'd0, last_item.op);
        chk("R1", 32'(sb_q.size()), 32'd0, 32'd0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule